// File: doc/BRIEF.md
# Periodic Wakeup and Reset Timer

This block counts strobes from a slow wakeup time base and raises a wakeup interrupt once a programmed number of strobes has elapsed. Software clears the interrupt by writing a one to an acknowledge bit. Each completed wakeup period also advances a second counter, which asks for a periodic system reset after a programmed number of wakeup periods.

The slow clock is a one-cycle enable, `tick_i`, that is synchronous to the system clock. Control and status pass through two byte-wide registers on a plain synchronous bus, which has an address, a write strobe, write data and combinational read data. An interlock refuses any write that would turn off both the wakeup interrupt and the periodic reset.

Top module: `wake_rst_timer`

## Requirements
- R1: Address 0 reads as {flag in bit 7, 0 in bit 6, wakeup interval in bits 5:0}. Bit 6 is the acknowledge and always reads 0. Address 1 reads the reset interval in bits 5:0, with bits 7:6 at 0. Addresses 2 and 3 read 0.
- R2: With a nonzero wakeup interval N, the flag sets on the clock edge that takes the N-th tick since the last restart or wrap. It then repeats every N ticks. `irq_o` equals the flag.
- R3: Writing address 0 with bit 6 set clears the flag, and bit 6 at 0 leaves the flag alone. A wakeup event in the same cycle as an acknowledge leaves the flag set.
- R4: Writing a wakeup interval that differs from the held value restarts the wakeup count. Rewriting the held value does not disturb the count.
- R5: A wakeup interval of 0 stops the flag from ever setting. The wakeup divider keeps running with a period of 63 ticks and still clocks the reset counter.
- R6: A write of 0 to either interval is refused while the other interval is 0. A refused write keeps the previous value and does not restart any count.
- R7: With a nonzero reset interval M, `prst_req_o` pulses high for one cycle after every M-th wakeup period, on the edge that takes the closing tick. A value of 0 produces no pulses. Changing the value restarts the reset count.
- R8: Reset sets both intervals to 63 and clears the flag, both counts and `prst_req_o`.
- R9: The counts advance only in cycles where `tick_i` is high. Without ticks the flag does not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow wakeup time base, one-cycle enable |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Wakeup interrupt (the flag) |
| prst_req_o | output | 1 | One-cycle periodic reset request |

## Verification
The checker treats `tick_i` as a synchronous enable that may be high in any cycle. It allows at most one register write per cycle, selected by `addr_i`. Its rule that an acknowledge clears the flag applies only in cycles with no tick, because a tick in that cycle may close a period and take priority. The bench drives every input on the falling edge and exercises the same-cycle case separately: it lines up an acknowledge with the closing tick and checks that the flag stays set.

// File: rtl/wrt_pkg.sv
package wrt_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned ACK_BIT  = 6;
  localparam int unsigned ADR_WAKE = 0;
  localparam int unsigned ADR_PRST = 1;
endpackage

// File: rtl/wrt_divider.sv
module wrt_divider #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         restart_i,
  input  logic [W-1:0] limit_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q >= limit_i - W'(1));
  assign wrap_o = step_i && !restart_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step_i)    cnt_q <= at_end ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/wrt_regs.sv
module wrt_regs
  import wrt_pkg::*;
#(
  parameter int unsigned IVL_W  = 6,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              period_i,
  output logic [IVL_W-1:0]  wake_ivl_o,
  output logic [IVL_W-1:0]  prst_ivl_o,
  output logic              flag_o,
  output logic              wake_restart_o,
  output logic              prst_restart_o,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [IVL_W-1:0] wake_q, prst_q, new_ivl;
  logic             flag_q, wr_wake, wr_prst, wake_evt;

  assign new_ivl = wdata_i[IVL_W-1:0];
  assign wr_wake = we_i && (addr_i == ADDR_W'(ADR_WAKE));
  assign wr_prst = we_i && (addr_i == ADDR_W'(ADR_PRST));

  // interlock: never leave both intervals at zero
  assign wake_restart_o = wr_wake && (new_ivl != wake_q) && !((new_ivl == '0) && (prst_q == '0));
  assign prst_restart_o = wr_prst && (new_ivl != prst_q) && !((new_ivl == '0) && (wake_q == '0));
  assign wake_evt       = period_i && (wake_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q <= '1;
      prst_q <= '1;
      flag_q <= 1'b0;
    end else begin
      if (wake_restart_o) wake_q <= new_ivl;
      if (prst_restart_o) prst_q <= new_ivl;
      if (wake_evt)                           flag_q <= 1'b1;
      else if (wr_wake && wdata_i[ACK_BIT])   flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADR_WAKE)) begin
      rdata_o[IVL_W-1:0] = wake_q;
      rdata_o[FLAG_BIT]  = flag_q;
    end else if (addr_i == ADDR_W'(ADR_PRST)) begin
      rdata_o[IVL_W-1:0] = prst_q;
    end
  end

  assign wake_ivl_o = wake_q;
  assign prst_ivl_o = prst_q;
  assign flag_o     = flag_q;
endmodule

// File: rtl/wake_rst_timer.sv
module wake_rst_timer
  import wrt_pkg::*;
#(
  parameter int unsigned IVL_W  = 6,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              prst_req_o
);
  logic [IVL_W-1:0] wake_ivl, prst_ivl, wake_lim;
  logic             wake_rs, prst_rs, wake_wrap, prst_wrap, prst_step, prst_q;

  // zero interval disables irq but keeps the time base at max period
  assign wake_lim  = (wake_ivl == '0) ? '1 : wake_ivl;
  assign prst_step = wake_wrap && (prst_ivl != '0);

  wrt_regs #(.IVL_W(IVL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .period_i      (wake_wrap),
    .wake_ivl_o    (wake_ivl),
    .prst_ivl_o    (prst_ivl),
    .flag_o        (irq_o),
    .wake_restart_o(wake_rs),
    .prst_restart_o(prst_rs),
    .rdata_o
  );

  wrt_divider #(.W(IVL_W)) u_wake_div (
    .clk_i, .rst_ni,
    .step_i   (tick_i),
    .restart_i(wake_rs),
    .limit_i  (wake_lim),
    .wrap_o   (wake_wrap)
  );

  wrt_divider #(.W(IVL_W)) u_prst_div (
    .clk_i, .rst_ni,
    .step_i   (prst_step),
    .restart_i(prst_rs),
    .limit_i  (prst_ivl),
    .wrap_o   (prst_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prst_q <= 1'b0;
    else         prst_q <= prst_wrap;
  end

  assign prst_req_o = prst_q;
endmodule

// File: rtl/wrt_checker.sv
module wrt_checker
  import wrt_pkg::*;
#(
  parameter int unsigned IVL_W  = 6,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              prst_req_o,
  input logic [IVL_W-1:0]  wake_ivl,
  input logic [IVL_W-1:0]  prst_ivl
);
  logic ack_wr;
  assign ack_wr = we_i && (addr_i == ADDR_W'(ADR_WAKE)) && wdata_i[ACK_BIT];

  p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_wr && !tick_i |=> !irq_o);
  p_flag_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_wr |=> irq_o);
  p_hold_ivl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(ADR_WAKE)) |=> $stable(wake_ivl));
  p_no_flag_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_ivl == '0) && !irq_o |=> !irq_o);
  p_not_both_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_ivl != '0) || (prst_ivl != '0));
  p_prst_after_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_req_o |-> $past(tick_i));
  p_tick_gates_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !irq_o |=> !irq_o);
endmodule

bind wake_rst_timer wrt_checker #(.IVL_W(IVL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .addr_i, .we_i, .wdata_i, .irq_o, .prst_req_o,
  .wake_ivl(wake_ivl), .prst_ivl(prst_ivl)
);

// File: tb/wake_rst_timer_tb_top.sv
module wake_rst_timer_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, prst;
  int tests = 0, fails = 0, pcnt = 0, p0;
  logic [7:0] rd;

  always #2 clk = ~clk;

  wake_rst_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .prst_req_o(prst)
  );

  always @(posedge clk) if (prst) pcnt <= pcnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit t, input bit w, input logic [1:0] a, input logic [7:0] d);
    tick = t; we = w; addr = a; wdata = d;
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    drive(1'b0, 1'b1, a, d);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 / R1 reset state and layout
    rd_reg(2'd0, rd); check(rd == 8'h3F, "R8 wake reset", rd, 8'h3F);
    rd_reg(2'd1, rd); check(rd == 8'h3F, "R8 prst reset", rd, 8'h3F);
    check(irq == 1'b0 && prst == 1'b0, "R8 outputs low", {irq, prst}, 0);
    rd_reg(2'd2, rd); check(rd == 8'h00, "R1 unused addr", rd, 0);
    rd_reg(2'd3, rd); check(rd == 8'h00, "R1 unused addr", rd, 0);

    // R2 sweep over every nonzero interval, two periods each
    for (int n = 1; n < 64; n++) begin
      wr(2'd0, 8'(n));
      wr(2'd0, 8'h40 | 8'(n));
      rd_reg(2'd0, rd); check(rd == 8'(n), "R1 readback ack reads 0", rd, n);
      for (int p = 0; p < 2; p++) begin
        ticks(n - 1);
        check(irq == 1'b0, "R2 before period", irq, 0);
        ticks(1);
        check(irq == 1'b1, "R2 at period", irq, 1);
        rd_reg(2'd0, rd); check(rd[7] == 1'b1, "R1 flag bit7", rd[7], 1);
        wr(2'd0, 8'h40 | 8'(n));
        check(irq == 1'b0, "R3 ack clears", irq, 0);
      end
    end

    // R4 same value keeps count, new value restarts
    wr(2'd0, 8'h05); ticks(3); wr(2'd0, 8'h05); ticks(2);
    check(irq == 1'b1, "R4 rewrite same keeps count", irq, 1);
    wr(2'd0, 8'h45); ticks(3); wr(2'd0, 8'h06); ticks(5);
    check(irq == 1'b0, "R4 change restarts", irq, 0);
    ticks(1);
    check(irq == 1'b1, "R4 full new period", irq, 1);

    // R3 ack bit zero ignored; event wins over ack
    wr(2'd0, 8'h86);
    check(irq == 1'b1, "R3 zero ack no effect", irq, 1);
    wr(2'd0, 8'h46); ticks(5);
    drive(1'b1, 1'b1, 2'd0, 8'h46);
    check(irq == 1'b1, "R3 event beats ack", irq, 1);
    wr(2'd0, 8'h46);
    check(irq == 1'b0, "R3 ack after", irq, 0);

    // R7 periodic reset every 3 periods of 2 ticks
    wr(2'd0, 8'h02); wr(2'd1, 8'h03); p0 = pcnt;
    ticks(5); drive(1'b0, 1'b0, 2'd0, 8'h00);
    check(pcnt == p0, "R7 no early pulse", pcnt - p0, 0);
    ticks(1);
    check(prst == 1'b1, "R7 pulse high", prst, 1);
    drive(1'b0, 1'b0, 2'd0, 8'h00);
    check(prst == 1'b0 && pcnt == p0 + 1, "R7 single cycle pulse", pcnt - p0, 1);

    // R5 zero wake interval: no flag, divider runs at 63
    wr(2'd0, 8'h40); wr(2'd0, 8'h40);
    rd_reg(2'd0, rd); check(rd == 8'h00, "R5 zero accepted", rd, 0);
    p0 = pcnt;
    ticks(188); drive(1'b0, 1'b0, 2'd0, 8'h00);
    check(pcnt == p0, "R5 no pulse before 189", pcnt - p0, 0);
    ticks(1);
    check(prst == 1'b1, "R5 divider feeds reset at 63", prst, 1);
    check(irq == 1'b0, "R5 flag never sets", irq, 0);

    // R6 interlock
    wr(2'd1, 8'h00);
    rd_reg(2'd1, rd); check(rd == 8'h03, "R6 prst zero refused", rd, 3);
    wr(2'd0, 8'h07); wr(2'd1, 8'h00);
    rd_reg(2'd1, rd); check(rd == 8'h00, "R6 prst zero allowed", rd, 0);
    wr(2'd0, 8'h00);
    rd_reg(2'd0, rd); check(rd == 8'h07, "R6 wake zero refused", rd, 7);

    // R7 zero reset interval: no pulses
    wr(2'd0, 8'h01); wr(2'd0, 8'h41); p0 = pcnt;
    ticks(70); drive(1'b0, 1'b0, 2'd0, 8'h00);
    check(pcnt == p0, "R7 zero disables pulses", pcnt - p0, 0);

    // R9 idle cycles do not count
    wr(2'd0, 8'h03); wr(2'd0, 8'h43);
    repeat (20) drive(1'b0, 1'b0, 2'd0, 8'h00);
    check(irq == 1'b0, "R9 no tick no flag", irq, 0);
    ticks(3);
    check(irq == 1'b1, "R9 ticks count", irq, 1);

    // R8 mid-run reset
    rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check(irq == 1'b0, "R8 flag cleared", irq, 0);
    rd_reg(2'd0, rd); check(rd == 8'h3F, "R8 wake preset", rd, 8'h3F);
    rd_reg(2'd1, rd); check(rd == 8'h3F, "R8 prst preset", rd, 8'h3F);
    finish_run();
  end
endmodule